// File: doc/BRIEF.md
# Development-Mode Fault Gate

This block sits between the fault detectors of a supply-and-supervision controller and the logic that carries out resets and fail-safe entry. Every cycle it looks at the watchdog overflow, watchdog window miss, interrupt time-out, start-up timer expiry and long-undervoltage flags, together with the current operating mode. From these it decides whether to request a system reset or a fail-safe transition. It also records a reset-source code in the status register through a write strobe.

A development mode changes that decision. While the mode is on, watchdog-class faults in normal mode and start-up expiry no longer reset the system. Instead they raise a one-cycle interrupt, and the source code is still written. Every fail-safe entry is blocked except the one caused by a sustained undervoltage. The watchdog in standby and sleep keeps its usual effect. An externally held reset line in start-up mode still moves the system to restart.

The development bit lives in a small latch state machine with three states: `LAT_POR`, `LAT_WINDOW` and `LAT_LOCKED`. In `LAT_POR`, the first clock after power-on, it samples the test strap. `LAT_POR` moves to `LAT_WINDOW` when the mode is start-up, and to `LAT_LOCKED` otherwise. In `LAT_WINDOW`, software writes to the bit are taken while the mode stays start-up. `LAT_WINDOW` moves to `LAT_LOCKED` as soon as the mode leaves start-up. `LAT_LOCKED` is left only by a power-on reset.

Top module: `devmode_fault_gate`

## Requirements
- R1: With development mode on, none of these gives `rst_req_o`: watchdog overflow, window miss or interrupt time-out in normal mode (mode 1), or start-up expiry in start-up mode (mode 0).
- R2: A fault suppressed by development mode still pulses `src_we_o` with its code on `src_o`, and it pulses `irq_o` in the same cycle.
- R3: Watchdog overflow in standby (mode 2) or sleep (mode 3) requests a reset with code 1, with or without development mode, and raises no interrupt.
- R4: With development mode on, no fault except a long undervoltage requests fail-safe. Start-up expiry in restart mode (mode 4) is suppressed. A long undervoltage still requests fail-safe with code 5.
- R5: `ext_rst_i` in start-up mode requests a reset (entry to restart) whatever the development mode is. It writes no source code.
- R6: A write to the development bit takes effect one cycle later only if the mode has been start-up without a break since power-on. Any other write is ignored and leaves `dev_mode_o` unchanged.
- R7: The test strap is sampled on the first clock after power-on reset is released. Changes to it after that have no effect.
- R8: Power-on reset clears `dev_mode_o`, `rst_req_o`, `fs_req_o`, `src_we_o`, `irq_o` and `src_o`.
- R9: Without development mode, these faults request a reset: overflow (code 1), window miss (code 2) and time-out (code 3) in normal mode, and start-up expiry in start-up mode (code 4). Start-up expiry in restart mode requests fail-safe with code 4. Code 0 means none.
- R10: When several faults arrive together, the highest one wins, in this order: undervoltage, overflow, window miss, time-out. Reset and fail-safe requests are never both high. In fail-safe mode (mode 5) all faults are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low (battery connect) |
| mode_i | input | 3 | Operating mode: 0 start-up, 1 normal, 2 standby, 3 sleep, 4 restart, 5 fail-safe |
| wd_ovf_i | input | 1 | Watchdog overflow event |
| wd_win_miss_i | input | 1 | Watchdog window miss event |
| int_tmo_i | input | 1 | Interrupt time-out event |
| stup_exp_i | input | 1 | Start-up timer expiry event |
| uv_long_i | input | 1 | Supply undervoltage longer than the clamp-time limit |
| ext_rst_i | input | 1 | Reset line held low externally |
| strap_i | input | 1 | Test strap selecting development mode at power-on |
| dev_wr_i | input | 1 | Write strobe for the development bit |
| dev_wdata_i | input | 1 | Value written to the development bit |
| rst_req_o | output | 1 | System reset request, one cycle per event |
| fs_req_o | output | 1 | Fail-safe request, one cycle per event |
| src_o | output | 3 | Last written reset-source code |
| src_we_o | output | 1 | Status register write strobe for `src_o` |
| irq_o | output | 1 | Interrupt in place of a suppressed fault |
| dev_mode_o | output | 1 | Development mode active |

## Verification
Every request, strobe, interrupt and source code is registered once. Each is therefore due on the first rising edge after the cycle that presents the fault. The development bit likewise changes on the first edge after an accepted write, or after the strap-sampling cycle. The bench drives inputs on the falling edge and lets one rising edge pass. It compares on the next falling edge, then clears the one-cycle fault inputs before the following rising edge. Ignored writes and strap changes are checked by reading `dev_mode_o` after several further edges.

// File: rtl/dbgf_pkg.sv
package dbgf_pkg;
    localparam int MODE_W = 3;
    localparam int SRC_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        OP_STARTUP  = 3'd0,
        OP_NORMAL   = 3'd1,
        OP_STANDBY  = 3'd2,
        OP_SLEEP    = 3'd3,
        OP_RESTART  = 3'd4,
        OP_FAILSAFE = 3'd5
    } op_mode_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE     = 3'd0,
        SRC_WD_OVF   = 3'd1,
        SRC_WIN_MISS = 3'd2,
        SRC_INT_TMO  = 3'd3,
        SRC_STUP     = 3'd4,
        SRC_UNDERV   = 3'd5
    } rst_src_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_RESET,
        ACT_FAILSAFE
    } fault_act_e;

    typedef enum logic [1:0] {
        LAT_POR,
        LAT_WINDOW,
        LAT_LOCKED
    } lat_state_e;

    typedef struct packed {
        logic       valid;
        rst_src_e   code;
        fault_act_e act;
        logic       maskable;
    } fault_ev_t;
endpackage

// File: rtl/dbgf_dev_latch.sv
module dbgf_dev_latch
    import dbgf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  op_mode_e mode_i,
    input  logic     strap_i,
    input  logic     wr_i,
    input  logic     wdata_i,
    output logic     dev_o
);
    lat_state_e state_q, state_d;
    logic       dev_q, dev_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LAT_POR;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and bit update
    always_comb begin
        state_d = state_q;
        dev_d   = dev_q;
        unique case (state_q)
            LAT_POR: begin
                dev_d   = strap_i;
                state_d = (mode_i == OP_STARTUP) ? LAT_WINDOW : LAT_LOCKED;
            end
            LAT_WINDOW: begin
                if (mode_i != OP_STARTUP) begin
                    state_d = LAT_LOCKED;
                end else if (wr_i) begin
                    dev_d = wdata_i;
                end
            end
            LAT_LOCKED: begin
                state_d = LAT_LOCKED;
            end
            default: state_d = LAT_LOCKED;
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_q <= 1'b0;
        end else begin
            dev_q <= dev_d;
        end
    end

    assign dev_o = dev_q;
endmodule

// File: rtl/dbgf_classify.sv
module dbgf_classify
    import dbgf_pkg::*;
(
    input  op_mode_e  mode_i,
    input  logic      uv_i,
    input  logic      wd_ovf_i,
    input  logic      win_i,
    input  logic      tmo_i,
    input  logic      stup_i,
    input  logic      ext_i,
    output fault_ev_t ev_o,
    output logic      ext_restart_o
);
    always_comb begin
        ev_o = '{valid: 1'b0, code: SRC_NONE, act: ACT_NONE, maskable: 1'b0};
        if (mode_i != OP_FAILSAFE) begin
            if (uv_i) begin
                ev_o = '{valid: 1'b1, code: SRC_UNDERV, act: ACT_FAILSAFE, maskable: 1'b0};
            end else begin
                unique case (mode_i)
                    OP_NORMAL: begin
                        if (wd_ovf_i) begin
                            ev_o = '{valid: 1'b1, code: SRC_WD_OVF, act: ACT_RESET, maskable: 1'b1};
                        end else if (win_i) begin
                            ev_o = '{valid: 1'b1, code: SRC_WIN_MISS, act: ACT_RESET, maskable: 1'b1};
                        end else if (tmo_i) begin
                            ev_o = '{valid: 1'b1, code: SRC_INT_TMO, act: ACT_RESET, maskable: 1'b1};
                        end
                    end
                    OP_STANDBY, OP_SLEEP: begin
                        if (wd_ovf_i) begin
                            ev_o = '{valid: 1'b1, code: SRC_WD_OVF, act: ACT_RESET, maskable: 1'b0};
                        end
                    end
                    OP_STARTUP: begin
                        if (stup_i) begin
                            ev_o = '{valid: 1'b1, code: SRC_STUP, act: ACT_RESET, maskable: 1'b1};
                        end
                    end
                    OP_RESTART: begin
                        if (stup_i) begin
                            ev_o = '{valid: 1'b1, code: SRC_STUP, act: ACT_FAILSAFE, maskable: 1'b1};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ext_restart_o = (mode_i == OP_STARTUP) && ext_i && !uv_i;
endmodule

// File: rtl/dbgf_gate.sv
module dbgf_gate
    import dbgf_pkg::*;
(
    input  fault_ev_t ev_i,
    input  logic      dev_i,
    input  logic      ext_restart_i,
    output logic      rst_d_o,
    output logic      fs_d_o,
    output logic      we_d_o,
    output logic      irq_d_o
);
    logic masked;

    always_comb begin
        masked  = ev_i.valid && ev_i.maskable && dev_i;
        rst_d_o = (ev_i.valid && (ev_i.act == ACT_RESET) && !masked) || ext_restart_i;
        fs_d_o  = ev_i.valid && (ev_i.act == ACT_FAILSAFE) && !masked;
        we_d_o  = ev_i.valid;
        irq_d_o = masked;
    end
endmodule

// File: rtl/devmode_fault_gate.sv
module devmode_fault_gate
    import dbgf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              wd_ovf_i,
    input  logic              wd_win_miss_i,
    input  logic              int_tmo_i,
    input  logic              stup_exp_i,
    input  logic              uv_long_i,
    input  logic              ext_rst_i,
    input  logic              strap_i,
    input  logic              dev_wr_i,
    input  logic              dev_wdata_i,
    output logic              rst_req_o,
    output logic              fs_req_o,
    output logic [SRC_W-1:0]  src_o,
    output logic              src_we_o,
    output logic              irq_o,
    output logic              dev_mode_o
);
    op_mode_e  mode;
    fault_ev_t ev;
    logic      ext_restart;
    logic      dev;
    logic      rst_d, fs_d, we_d, irq_d;

    assign mode = op_mode_e'(mode_i);

    dbgf_dev_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .strap_i (strap_i),
        .wr_i    (dev_wr_i),
        .wdata_i (dev_wdata_i),
        .dev_o   (dev)
    );

    dbgf_classify u_classify (
        .mode_i        (mode),
        .uv_i          (uv_long_i),
        .wd_ovf_i      (wd_ovf_i),
        .win_i         (wd_win_miss_i),
        .tmo_i         (int_tmo_i),
        .stup_i        (stup_exp_i),
        .ext_i         (ext_rst_i),
        .ev_o          (ev),
        .ext_restart_o (ext_restart)
    );

    dbgf_gate u_gate (
        .ev_i          (ev),
        .dev_i         (dev),
        .ext_restart_i (ext_restart),
        .rst_d_o       (rst_d),
        .fs_d_o        (fs_d),
        .we_d_o        (we_d),
        .irq_d_o       (irq_d)
    );

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req_o <= 1'b0;
            fs_req_o  <= 1'b0;
            src_we_o  <= 1'b0;
            irq_o     <= 1'b0;
            src_o     <= SRC_NONE;
        end else begin
            rst_req_o <= rst_d;
            fs_req_o  <= fs_d;
            src_we_o  <= we_d;
            irq_o     <= irq_d;
            if (we_d) begin
                src_o <= ev.code;
            end
        end
    end

    assign dev_mode_o = dev;
endmodule

// File: rtl/devmode_fault_gate_chk.sv
module devmode_fault_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_i,
    input logic       wd_ovf_i,
    input logic       wd_win_miss_i,
    input logic       int_tmo_i,
    input logic       stup_exp_i,
    input logic       uv_long_i,
    input logic       ext_rst_i,
    input logic       dev_wr_i,
    input logic       rst_req_o,
    input logic       fs_req_o,
    input logic [2:0] src_o,
    input logic       src_we_o,
    input logic       irq_o,
    input logic       dev_mode_o
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R1: watchdog-class faults in normal mode give no reset under development mode
    a_r1_no_reset_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_mode_o && mode_i == 3'd1 && !uv_long_i && (wd_ovf_i || wd_win_miss_i || int_tmo_i))
        |=> !rst_req_o);

    // R1: start-up expiry gives no reset under development mode
    a_r1_no_reset_stup: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_mode_o && mode_i == 3'd0 && stup_exp_i && !ext_rst_i && !uv_long_i)
        |=> !rst_req_o);

    // R2: suppressed overflow still writes its code and raises an interrupt
    a_r2_src_written: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_mode_o && mode_i == 3'd1 && wd_ovf_i && !uv_long_i)
        |=> (src_we_o && irq_o && src_o == 3'd1));

    // R2: an interrupt always comes with a source write
    a_r2_irq_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> src_we_o);

    // R3: low-power watchdog overflow always resets
    a_r3_lowpower_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 3'd2 || mode_i == 3'd3) && wd_ovf_i && !uv_long_i)
        |=> (rst_req_o && src_o == 3'd1 && !irq_o));

    // R4: long undervoltage forces fail-safe
    a_r4_uv_failsafe: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 3'd5 && uv_long_i) |=> (fs_req_o && src_o == 3'd5));

    // R4: no other fail-safe under development mode
    a_r4_fs_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_mode_o && !uv_long_i) |=> !fs_req_o);

    // R5: external reset in start-up restarts
    a_r5_ext_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd0 && ext_rst_i && !uv_long_i) |=> rst_req_o);

    // R6: write outside start-up is ignored
    a_r6_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dev_wr_i && mode_i != 3'd0) |=> $stable(dev_mode_o));

    // R7: without a write the bit never moves after the strap sample
    a_r7_strap_once: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !dev_wr_i) |=> $stable(dev_mode_o));

    // R10: requests are exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_req_o, fs_req_o}));

    // R10: fail-safe mode ignores every fault
    a_r10_fs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd5) |=> (!rst_req_o && !fs_req_o && !src_we_o && !irq_o));
endmodule

bind devmode_fault_gate devmode_fault_gate_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .wd_ovf_i      (wd_ovf_i),
    .wd_win_miss_i (wd_win_miss_i),
    .int_tmo_i     (int_tmo_i),
    .stup_exp_i    (stup_exp_i),
    .uv_long_i     (uv_long_i),
    .ext_rst_i     (ext_rst_i),
    .dev_wr_i      (dev_wr_i),
    .rst_req_o     (rst_req_o),
    .fs_req_o      (fs_req_o),
    .src_o         (src_o),
    .src_we_o      (src_we_o),
    .irq_o         (irq_o),
    .dev_mode_o    (dev_mode_o)
);

// File: tb/test_devmode_fault_gate.sv
module test_devmode_fault_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_i = 3'd0;
    logic       wd_ovf_i = 0, wd_win_miss_i = 0, int_tmo_i = 0, stup_exp_i = 0;
    logic       uv_long_i = 0, ext_rst_i = 0, strap_i = 0, dev_wr_i = 0, dev_wdata_i = 0;
    logic       rst_req_o, fs_req_o, src_we_o, irq_o, dev_mode_o;
    logic [2:0] src_o;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    devmode_fault_gate i_devmode_fault_gate (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wd_ovf_i(wd_ovf_i),
        .wd_win_miss_i(wd_win_miss_i), .int_tmo_i(int_tmo_i), .stup_exp_i(stup_exp_i),
        .uv_long_i(uv_long_i), .ext_rst_i(ext_rst_i), .strap_i(strap_i),
        .dev_wr_i(dev_wr_i), .dev_wdata_i(dev_wdata_i), .rst_req_o(rst_req_o),
        .fs_req_o(fs_req_o), .src_o(src_o), .src_we_o(src_we_o), .irq_o(irq_o),
        .dev_mode_o(dev_mode_o)
    );

    // {dev, mode[3], uv ovf win tmo stup ext, rst fs we, src[3], irq, pad}
    localparam int NV = 20;
    localparam logic [17:0] VEC [NV] = '{
        18'b0_001_010000_101_001_0_0,
        18'b0_001_001000_101_010_0_0,
        18'b0_001_000100_101_011_0_0,
        18'b0_000_000010_101_100_0_0,
        18'b0_100_000010_011_100_0_0,
        18'b0_010_010000_101_001_0_0,
        18'b0_001_110000_011_101_0_0,
        18'b0_101_110000_000_000_0_0,
        18'b0_000_000001_100_000_0_0,
        18'b0_001_011000_101_001_0_0,
        18'b1_001_010000_001_001_1_0,
        18'b1_001_001000_001_010_1_0,
        18'b1_001_000100_001_011_1_0,
        18'b1_000_000010_001_100_1_0,
        18'b1_100_000010_001_100_1_0,
        18'b1_011_010000_101_001_0_0,
        18'b1_010_010000_101_001_0_0,
        18'b1_001_100000_011_101_0_0,
        18'b1_000_000001_100_000_0_0,
        18'b1_000_000011_101_100_1_0
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1, 2, 3, 4:      return "R9";
            5, 15, 16:          return "R3";
            6, 7, 9:            return "R10";
            8, 18, 19:          return "R5";
            10, 11, 12, 13:     return "R1/R2";
            default:            return "R4";
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_ins();
        wd_ovf_i = 0; wd_win_miss_i = 0; int_tmo_i = 0; stup_exp_i = 0;
        uv_long_i = 0; ext_rst_i = 0; dev_wr_i = 0; dev_wdata_i = 0;
    endtask

    // Called at a falling edge; returns at the falling edge after the strap sample
    task automatic power_on(logic s);
        rst_n = 0; strap_i = s; mode_i = 3'd0; clear_ins();
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [17:0] v;
        @(negedge clk);
        // R8: reset state while power-on reset is held
        strap_i = 1;
        @(negedge clk);
        chk("R8", "dev in reset", dev_mode_o, 0);
        chk("R8", "requests in reset", {rst_req_o, fs_req_o, src_we_o, irq_o}, 0);
        chk("R8", "src in reset", src_o, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            if (i == 0 || v[17] != VEC[i-1][17]) begin
                power_on(v[17]);
                chk("R7", "dev after power-on", dev_mode_o, v[17]);
            end
            mode_i = v[16:14];
            {uv_long_i, wd_ovf_i, wd_win_miss_i, int_tmo_i, stup_exp_i, ext_rst_i} = v[13:8];
            step();
            clear_ins();
            chk(tag_of(i), "rst_req", rst_req_o, v[7]);
            chk(tag_of(i), "fs_req", fs_req_o, v[6]);
            chk(tag_of(i), "src_we", src_we_o, v[5]);
            chk(tag_of(i), "irq", irq_o, v[1]);
            if (v[5]) chk(tag_of(i), "src code", src_o, v[4:2]);
        end

        // R7: strap change after power-on is ignored
        power_on(1'b1);
        chk("R7", "strap set", dev_mode_o, 1);
        strap_i = 0;
        repeat (4) step();
        chk("R7", "strap dropped later", dev_mode_o, 1);
        power_on(1'b0);
        chk("R8", "power-on clears bit", dev_mode_o, 0);

        // R6: write window
        dev_wr_i = 1; dev_wdata_i = 1; step(); clear_ins();
        chk("R6", "write in start-up", dev_mode_o, 1);
        dev_wr_i = 1; dev_wdata_i = 0; step(); clear_ins();
        chk("R6", "clear in start-up", dev_mode_o, 0);
        mode_i = 3'd1; dev_wr_i = 1; dev_wdata_i = 1; step(); clear_ins();
        chk("R6", "write in normal ignored", dev_mode_o, 0);
        mode_i = 3'd0; dev_wr_i = 1; dev_wdata_i = 1; step(); clear_ins();
        step();
        chk("R6", "write after leaving start-up ignored", dev_mode_o, 0);
        mode_i = 3'd1; int_tmo_i = 1; step(); clear_ins();
        chk("R6", "locked bit keeps reset path", rst_req_o, 1);

        // R6/R1: bit set by software suppresses a time-out
        power_on(1'b0);
        dev_wr_i = 1; dev_wdata_i = 1; step(); clear_ins();
        mode_i = 3'd1; int_tmo_i = 1; step(); clear_ins();
        chk("R1", "software-set mode suppresses", rst_req_o, 0);
        chk("R2", "software-set mode irq", irq_o, 1);
        chk("R2", "software-set mode code", src_o, 3);
        step();
        chk("R2", "irq lasts one cycle", irq_o, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule